// File: doc/BRIEF.md
# Switch-Configured Memory Window Decoder

This block decides, for every bus cycle, whether a memory board owns the byte address on an 18-bit bus. The board's window is set by two banks of active-low configuration switches: one picks where the window starts, the other picks how large it is. Each start switch and each size switch adds a fixed power-of-two weight when it reads 0. The size always includes a built-in minimum of one 8 KiB grain. The top 8 KiB of the address space is reserved for peripheral registers, so it is never claimed, whatever the switches say.

For a claimed cycle, the block also produces the board-relative word address: the byte distance from the window start, with the byte-select bit dropped. The two bits above the 14-bit in-bank word index pick one of four 16K-word storage banks. Outputs are registered and appear one clock after the address and strobe are presented. If the window would extend past the top of the 18-bit space, it is clipped at the top. It never wraps round to low addresses.

Top module: `mem_window_decode`

## Requirements
- R1: While `rst` is high at a rising clock edge, the registered outputs `mem_sel`, `word_addr` and `bank_sel` become 0.
- R2: The window start, in bytes, is the sum of octal 020000 << i over every bit i of `sw_start_n` (i = 0..4) that reads 0. Bit 4 carries octal 400000 and bit 0 carries octal 020000.
- R3: The window size, in bytes, is octal 020000 plus the sum of octal 020000 << i over every bit i of `sw_size_n` (i = 0..3) that reads 0. Bit 3 carries octal 200000.
- R4: `mem_sel` is 1 in the cycle after an edge at which `cycle_stb` was 1 and start ≤ `bus_addr` < start + size and `bus_addr` < octal 760000. Otherwise it is 0.
- R5: An edge with `cycle_stb` at 0 yields `mem_sel` = 0 whatever the address and switches.
- R6: No address from octal 760000 to 777777 is ever claimed, even when the window covers it.
- R7: When selected, `word_addr` = (`bus_addr` − start) >> 1 (16 bits) and `bank_sel` = `word_addr`[15:14].
- R8: start + size is evaluated without truncation. A window running past octal 777777 claims nothing below its start.
- R9: When `mem_sel` is 0, `word_addr` and `bank_sel` are 0.
- R10: Byte addresses 2k and 2k+1 inside the window give the same `word_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 18 | Byte address of the current bus cycle |
| cycle_stb | input | 1 | High while a bus cycle is presented |
| sw_start_n | input | 5 | Active-low start switches, bit 4 heaviest |
| sw_size_n | input | 4 | Active-low size switches, bit 3 heaviest |
| mem_sel | output | 1 | Board claims the cycle (registered) |
| word_addr | output | 16 | Board-relative word address (registered) |
| bank_sel | output | 2 | Storage bank index, top bits of word_addr (registered) |

## Verification
Every path from the inputs to the outputs passes through exactly one register. A wrong switch weight, a wrong comparison or a wrong subtraction therefore shows at the ports one clock after the faulty vector is presented. Boundary addresses at start−2, start, start+size−2 and start+size, swept over all 512 switch settings, expose off-by-one errors on either edge of the window. A carry lost in the window end shows as a spurious claim of low memory when the window starts high with a large size. A leaking offset register shows as nonzero `word_addr` on a cycle that is not claimed.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

    localparam int DEF_ADDR_W      = 18;
    localparam int DEF_START_SW_W  = 5;
    localparam int DEF_SIZE_SW_W   = 4;
    localparam int DEF_GRAIN_LG    = 13;
    localparam int DEF_IOPAGE_LG   = 13;
    localparam int DEF_BANK_WRD_LG = 14;

    typedef struct packed {
        logic at_or_above_base;
        logic below_limit;
        logic below_io_page;
    } range_flags_t;

    function automatic logic flags_hit(input range_flags_t f);
        return f.at_or_above_base & f.below_limit & f.below_io_page;
    endfunction

endpackage

// File: rtl/mwd_switch_decode.sv
module mwd_switch_decode #(
    parameter int ADDR_W     = mwd_pkg::DEF_ADDR_W,
    parameter int START_SW_W = mwd_pkg::DEF_START_SW_W,
    parameter int SIZE_SW_W  = mwd_pkg::DEF_SIZE_SW_W,
    parameter int GRAIN_LG   = mwd_pkg::DEF_GRAIN_LG
) (
    input  logic [START_SW_W-1:0] sw_start_n,
    input  logic [SIZE_SW_W-1:0]  sw_size_n,
    output logic [ADDR_W-1:0]     win_base,
    output logic [ADDR_W:0]       win_limit
);
    localparam logic [ADDR_W:0] GRAIN = (ADDR_W+1)'(1) << GRAIN_LG;

    logic [ADDR_W:0] win_size;

    always_comb begin
        win_base = '0;
        win_base[GRAIN_LG +: START_SW_W] = ~sw_start_n;
        win_size = '0;
        win_size[GRAIN_LG +: SIZE_SW_W] = ~sw_size_n;
        win_size = win_size + GRAIN;
        // one extra bit keeps the end of the window from wrapping
        win_limit = {1'b0, win_base} + win_size;
    end
endmodule

// File: rtl/mwd_range_check.sv
module mwd_range_check #(
    parameter int ADDR_W    = mwd_pkg::DEF_ADDR_W,
    parameter int IOPAGE_LG = mwd_pkg::DEF_IOPAGE_LG
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [ADDR_W-1:0]          win_base,
    input  logic [ADDR_W:0]            win_limit,
    output mwd_pkg::range_flags_t      flags
);
    always_comb begin
        flags.at_or_above_base = (addr >= win_base);
        flags.below_limit      = ({1'b0, addr} < win_limit);
        // the I/O page is the region where every bit above IOPAGE_LG is set
        flags.below_io_page    = ~(&addr[ADDR_W-1:IOPAGE_LG]);
    end
endmodule

// File: rtl/mwd_offset.sv
module mwd_offset #(
    parameter int WORD_W = 16,
    parameter int BANK_W = 2
) (
    input  logic [WORD_W-1:0] addr_words,
    input  logic [WORD_W-1:0] base_words,
    output logic [WORD_W-1:0] rel_word,
    output logic [BANK_W-1:0] bank
);
    always_comb begin
        rel_word = addr_words - base_words;
        bank     = rel_word[WORD_W-1 -: BANK_W];
    end
endmodule

// File: rtl/mem_window_decode.sv
module mem_window_decode #(
    parameter int ADDR_W      = mwd_pkg::DEF_ADDR_W,
    parameter int START_SW_W  = mwd_pkg::DEF_START_SW_W,
    parameter int SIZE_SW_W   = mwd_pkg::DEF_SIZE_SW_W,
    parameter int GRAIN_LG    = mwd_pkg::DEF_GRAIN_LG,
    parameter int IOPAGE_LG   = mwd_pkg::DEF_IOPAGE_LG,
    parameter int BANK_WRD_LG = mwd_pkg::DEF_BANK_WRD_LG,
    localparam int WORD_W     = GRAIN_LG + SIZE_SW_W - 1,
    localparam int BANK_W     = WORD_W - BANK_WRD_LG
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  cycle_stb,
    input  logic [START_SW_W-1:0] sw_start_n,
    input  logic [SIZE_SW_W-1:0]  sw_size_n,
    output logic                  mem_sel,
    output logic [WORD_W-1:0]     word_addr,
    output logic [BANK_W-1:0]     bank_sel
);
    logic [ADDR_W-1:0]     win_base;
    logic [ADDR_W:0]       win_limit;
    mwd_pkg::range_flags_t flags;
    logic [WORD_W-1:0]     rel_word;
    logic [BANK_W-1:0]     rel_bank;
    logic                  hit;

    mwd_switch_decode #(
        .ADDR_W(ADDR_W), .START_SW_W(START_SW_W),
        .SIZE_SW_W(SIZE_SW_W), .GRAIN_LG(GRAIN_LG)
    ) u_sw (
        .sw_start_n(sw_start_n), .sw_size_n(sw_size_n),
        .win_base(win_base), .win_limit(win_limit)
    );

    mwd_range_check #(.ADDR_W(ADDR_W), .IOPAGE_LG(IOPAGE_LG)) u_rng (
        .addr(bus_addr), .win_base(win_base),
        .win_limit(win_limit), .flags(flags)
    );

    mwd_offset #(.WORD_W(WORD_W), .BANK_W(BANK_W)) u_off (
        .addr_words(bus_addr[WORD_W:1]), .base_words(win_base[WORD_W:1]),
        .rel_word(rel_word), .bank(rel_bank)
    );

    assign hit = cycle_stb & mwd_pkg::flags_hit(flags);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_sel   <= 1'b0;
            word_addr <= '0;
            bank_sel  <= '0;
        end else begin
            mem_sel   <= hit;
            word_addr <= hit ? rel_word : '0;
            bank_sel  <= hit ? rel_bank : '0;
        end
    end
endmodule

// File: rtl/mwd_checker.sv
module mwd_checker #(
    parameter int ADDR_W     = 18,
    parameter int START_SW_W = 5,
    parameter int SIZE_SW_W  = 4,
    parameter int GRAIN_LG   = 13,
    parameter int IOPAGE_LG  = 13,
    parameter int WORD_W     = 16,
    parameter int BANK_W     = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  cycle_stb,
    input logic [START_SW_W-1:0] sw_start_n,
    input logic [SIZE_SW_W-1:0]  sw_size_n,
    input logic                  mem_sel,
    input logic [WORD_W-1:0]     word_addr,
    input logic [BANK_W-1:0]     bank_sel
);
    localparam logic [ADDR_W:0] IO_FLOOR =
        ((ADDR_W+1)'(1) << ADDR_W) - ((ADDR_W+1)'(1) << IOPAGE_LG);

    logic [ADDR_W:0] lo_b, hi_b;
    always_comb begin
        lo_b = '0;
        lo_b[GRAIN_LG +: START_SW_W] = ~sw_start_n;
        hi_b = '0;
        hi_b[GRAIN_LG +: SIZE_SW_W] = ~sw_size_n;
        hi_b = hi_b + ((ADDR_W+1)'(1) << GRAIN_LG) + lo_b;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!mem_sel && word_addr == '0 && bank_sel == '0));

    assert_lower_edge_R2: assert property (@(posedge clk) disable iff (rst)
        mem_sel |-> ({1'b0, $past(bus_addr)} >= $past(lo_b)));

    assert_upper_edge_R8: assert property (@(posedge clk) disable iff (rst)
        mem_sel |-> ({1'b0, $past(bus_addr)} < $past(hi_b)));

    assert_needs_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        mem_sel |-> $past(cycle_stb));

    assert_io_excluded_R6: assert property (@(posedge clk) disable iff (rst)
        mem_sel |-> ({1'b0, $past(bus_addr)} < IO_FLOOR));

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !mem_sel |-> (word_addr == '0 && bank_sel == '0));
endmodule

bind mem_window_decode mwd_checker #(
    .ADDR_W(ADDR_W), .START_SW_W(START_SW_W), .SIZE_SW_W(SIZE_SW_W),
    .GRAIN_LG(GRAIN_LG), .IOPAGE_LG(IOPAGE_LG), .WORD_W(WORD_W), .BANK_W(BANK_W)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .cycle_stb(cycle_stb),
    .sw_start_n(sw_start_n), .sw_size_n(sw_size_n),
    .mem_sel(mem_sel), .word_addr(word_addr), .bank_sel(bank_sel)
);

// File: tb/sim_mem_window_decode.sv
module sim_mem_window_decode;
    localparam int CLK_PERIOD = 10;
    localparam int IO_FLOOR   = 'o760000;
    localparam int SPACE      = 1 << 18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [17:0] bus_addr = '0;
    logic        cycle_stb = 1'b0;
    logic [4:0]  sw_start_n = 5'b11111;
    logic [3:0]  sw_size_n = 4'b1111;
    logic        mem_sel;
    logic [15:0] word_addr;
    logic [1:0]  bank_sel;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_window_decode u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .cycle_stb(cycle_stb),
        .sw_start_n(sw_start_n), .sw_size_n(sw_size_n),
        .mem_sel(mem_sel), .word_addr(word_addr), .bank_sel(bank_sel)
    );

    function automatic int start_of(input logic [4:0] s);
        int b = 0;
        for (int i = 0; i < 5; i++) if (!s[i]) b += 'o20000 << i;
        return b;
    endfunction

    function automatic int size_of(input logic [3:0] s);
        int z = 'o20000;
        for (int i = 0; i < 4; i++) if (!s[i]) z += 'o20000 << i;
        return z;
    endfunction

    task automatic apply_check(input int a, input logic stb, input string req);
        int base, lim, e_word, e_bank;
        logic e_sel;
        @(negedge clk);
        bus_addr  = 18'(a);
        cycle_stb = stb;
        base = start_of(sw_start_n);
        lim  = base + size_of(sw_size_n);
        e_sel  = stb && a >= base && a < lim && a < IO_FLOOR;
        e_word = e_sel ? ((a - base) >> 1) : 0;
        e_bank = e_word >> 14;
        @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (mem_sel !== e_sel || int'(word_addr) != e_word || int'(bank_sel) != e_bank) begin
            n_bad++;
            $display("FAIL %s addr=%06o start_n=%b size_n=%b: got sel=%0b word=%0d bank=%0d, expected sel=%0b word=%0d bank=%0d",
                     req, a, sw_start_n, sw_size_n, mem_sel, word_addr, bank_sel,
                     e_sel, e_word, e_bank);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        rst = 1'b1; cycle_stb = 1'b1; bus_addr = '0;
        sw_start_n = 5'b11111; sw_size_n = 4'b0000;
        @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (mem_sel !== 1'b0 || word_addr !== '0 || bank_sel !== '0) begin
            n_bad++;
            $display("FAIL R1 reset: got sel=%0b word=%0d bank=%0d, expected 0 0 0",
                     mem_sel, word_addr, bank_sel);
        end
        rst = 1'b0;
    endtask

    // R2 R3 R4 R7: every switch setting, both edges of the window
    task automatic test_sweep();
        for (int s = 0; s < 32; s++) begin
            for (int z = 0; z < 16; z++) begin
                int b, e;
                sw_start_n = 5'(s);
                sw_size_n  = 4'(z);
                b = start_of(5'(s));
                e = b + size_of(4'(z));
                if (b >= 2) apply_check(b - 2, 1'b1, "R2");
                apply_check(b, 1'b1, "R2");
                if (e - 2 < SPACE) apply_check(e - 2, 1'b1, "R3");
                if (e < SPACE) apply_check(e, 1'b1, "R3");
                if (b + 'o40002 < SPACE) apply_check(b + 'o40002, 1'b1, "R7");
            end
        end
    endtask

    task automatic test_strobe_low();
        sw_start_n = 5'b11111; sw_size_n = 4'b0000;
        apply_check('o000100, 1'b0, "R5");
        apply_check('o177776, 1'b0, "R5");
        apply_check('o000100, 1'b1, "R4");
        apply_check('o000102, 1'b0, "R9");
    endtask

    task automatic test_io_page();
        sw_start_n = 5'b10000; sw_size_n = 4'b0000;
        apply_check('o757776, 1'b1, "R6");
        apply_check('o760000, 1'b1, "R6");
        apply_check('o777776, 1'b1, "R6");
        sw_start_n = 5'b00000;
        apply_check('o760000, 1'b1, "R6");
    endtask

    task automatic test_saturation();
        sw_start_n = 5'b00001; sw_size_n = 4'b0000;
        apply_check('o000000, 1'b1, "R8");
        apply_check('o137776, 1'b1, "R8");
        apply_check('o740000, 1'b1, "R8");
        apply_check('o757776, 1'b1, "R8");
    endtask

    task automatic test_odd_bytes();
        sw_start_n = 5'b11100; sw_size_n = 4'b0011;
        apply_check('o140000, 1'b1, "R10");
        apply_check('o140001, 1'b1, "R10");
        apply_check('o277777, 1'b1, "R10");
        apply_check('o277776, 1'b1, "R10");
        apply_check('o300000, 1'b1, "R10");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run hung, got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        test_reset();
        test_strobe_low();
        test_io_page();
        test_saturation();
        test_odd_bytes();
        test_sweep();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule